// File: doc/BRIEF.md
# Shadowed Raster Timing Generator

This block produces the horizontal sync, vertical sync, data-enable and pixel coordinates that drive a parallel RGB panel. All of it runs on one clock. A pixel-enable input (`pixTick`) moves the raster position on by one pixel. Software programs the geometry through a simple write port with address, data and strobe. The geometry is the sync width, back porch, active size and front porch of each axis. Every value is written as the wanted count minus one.

Register writes land in a shadow set. The timing the panel sees changes only at a frame boundary, and only when an update request is pending and the protect bit is clear. Software can therefore rewrite a whole mode field by field without the panel ever showing a half-written mix. The update request clears itself once the copy has been made. A frame interrupt can be raised at the start of each vertical sync and is cleared by writing a one. A line-match output flags the line chosen by a threshold register.

Top module: `shadow_vtg`

## Requirements
- R1: After `rstN` is released, `hsync`, `vsync`, `de`, `lineMatch` and `irq` are 0 and `pixX`/`pixY` are 0.
- R2: While running, each line is made of four regions in a fixed order. Sync comes first and lasts (addr 1)+1 ticks, then back porch for (addr 2)+1 ticks, then active for (addr 3)+1 ticks, then front porch for (addr 4)+1 ticks. `hsync` is high only in the sync region.
- R3: Lines are grouped into frames in the same order. The counts are (addr 5)+1 sync lines, (addr 6)+1 back-porch lines, (addr 7)+1 active lines and (addr 8)+1 front-porch lines. `vsync` is high only in the sync lines.
- R4: `de` is high exactly when both axes are in their active region. `pixX`/`pixY` then give the offset from the first active pixel and the first active line, and they are 0 whenever `de` is low.
- R5: Writes to addresses 1–8 and to the enable bit (addr 0 bit 0) go to a shadow set and do not change the outputs until a copy takes place.
- R6: The copy happens at a frame boundary only if an update request (addr 0 bit 1 written as 1) is pending. The request clears itself when the copy is made, so later boundaries do not copy newer shadow values.
- R7: While the protect bit (addr 0 bit 2) is 1, no copy happens at a boundary. Once protect is written back to 0, a still-pending request is copied at the next boundary.
- R8: The interrupt pending flag, seen on `irq`, is set at the tick that starts a new running frame, but only if both the global enable (addr 10 bit 0) and the frame enable (addr 10 bit 1) are 1.
- R9: Writing 1 to addr 11 bit 0 clears the pending flag on the next cycle.
- R10: `lineMatch` is high while running and the current line index, counted from 0 at the first sync line, equals the threshold in addr 9.
- R11: When the active enable is 0, the outputs stay low and the position stays at 0. Every tick while in this state counts as a frame boundary, so a pending copy is made at the first tick.
- R12: Writing addr 0 with bit 3 set is a soft reset, and the other bits of that write are ignored. It zeroes the position and the active set (which leaves video disabled) and clears both the pending update and the pending interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pixTick | input | 1 | Pixel enable; advances the raster by one pixel |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | AW | Register address |
| wrData | input | FW | Register write data |
| hsync | output | 1 | Horizontal sync, active high |
| vsync | output | 1 | Vertical sync, active high |
| de | output | 1 | Data enable, high in the active area |
| pixX | output | FW | Active pixel column, 0 outside the active area |
| pixY | output | FW | Active line row, 0 outside the active area |
| lineMatch | output | 1 | Current line equals the threshold |
| irq | output | 1 | Frame interrupt pending |

## Verification
The raster outputs are decoded without registers from the position counters. The values seen during a tick cycle therefore belong to the current position. The counters move on at the edge that consumes the tick, and a copy made at a boundary edge shows up at the very next tick. The bench samples on the falling clock edge of each tick cycle and compares against a queue of expected positions. The idle tick that makes the first copy is expected to show all zeros. The interrupt flag is registered, so it is checked several ticks after a boundary, and the clear is checked on the falling edge after the write edge.

// File: rtl/shadow_vtg_pkg.sv
package shadow_vtg_pkg;
  localparam int NUM_FIELDS = 8;
  localparam int FIELDS_PER_AXIS = 4;
  // field order inside one axis follows the raster sequence
  localparam int F_SYNC = 0;
  localparam int F_BACK = 1;
  localparam int F_ACT  = 2;
  localparam int F_FRONT = 3;

  localparam int ADDR_CTRL   = 0;
  localparam int ADDR_FIELD0 = 1;
  localparam int ADDR_LTHR   = 9;
  localparam int ADDR_IRQEN  = 10;
  localparam int ADDR_IRQCLR = 11;

  localparam int CB_EN   = 0;
  localparam int CB_UPD  = 1;
  localparam int CB_PROT = 2;
  localparam int CB_SRST = 3;

  typedef struct packed {
    logic run;    // active video enable
    logic clear;  // soft reset pulse
  } vtgCmd_t;

  typedef struct packed {
    logic frameEdge;   // boundary where a shadow copy may occur
    logic vsyncPoint;  // running frame wraps into a new vsync
  } vtgEvt_t;
endpackage

// File: rtl/shadow_vtg_axis.sv
module shadow_vtg_axis #(
  parameter int FW = 12,
  localparam int CW = FW + 2
) (
  input  logic [CW-1:0] cnt,
  input  logic [FW-1:0] syncM1,
  input  logic [FW-1:0] backM1,
  input  logic [FW-1:0] actM1,
  input  logic [FW-1:0] frontM1,
  output logic [CW-1:0] lastPos,
  output logic          inSync,
  output logic          inAct,
  output logic [FW-1:0] offs
);
  logic [CW-1:0] syncEnd, actBeg, actEnd, total, rel;

  always_comb begin
    syncEnd = CW'(syncM1) + CW'(1);
    actBeg  = syncEnd + CW'(backM1) + CW'(1);
    actEnd  = actBeg + CW'(actM1) + CW'(1);
    total   = actEnd + CW'(frontM1) + CW'(1);
    lastPos = total - CW'(1);
    inSync  = cnt < syncEnd;
    inAct   = (cnt >= actBeg) && (cnt < actEnd);
    rel     = cnt - actBeg;
    offs    = rel[FW-1:0];
  end
endmodule

// File: rtl/shadow_vtg_ctrl.sv
module shadow_vtg_ctrl
  import shadow_vtg_pkg::*;
#(
  parameter int FW = 12,
  parameter int AW = 4
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          wrEn,
  input  logic [AW-1:0]                 wrAddr,
  input  logic [FW-1:0]                 wrData,
  input  vtgEvt_t                       evt,
  output vtgCmd_t                       cmd,
  output logic [NUM_FIELDS-1:0][FW-1:0] actT,
  output logic [FW-1:0]                 lineThr,
  output logic                          irq
);
  logic [NUM_FIELDS-1:0][FW-1:0] shadowT;
  logic shadowEn, actEn, protect, updPend;
  logic gIrqEn, fIrqEn, irqPend;
  logic wrCtrl, softRst, ctrlWr, doCopy, irqClr, irqSet;

  always_comb begin
    wrCtrl  = wrEn && (int'(wrAddr) == ADDR_CTRL);
    softRst = wrCtrl && wrData[CB_SRST];
    ctrlWr  = wrCtrl && !wrData[CB_SRST];
    doCopy  = evt.frameEdge && updPend && !protect;
    irqClr  = wrEn && (int'(wrAddr) == ADDR_IRQCLR) && wrData[0];
    irqSet  = evt.vsyncPoint && gIrqEn && fIrqEn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shadowT  <= '0;
      shadowEn <= 1'b0;
      protect  <= 1'b0;
      lineThr  <= '0;
      gIrqEn   <= 1'b0;
      fIrqEn   <= 1'b0;
    end else if (wrEn) begin
      for (int i = 0; i < NUM_FIELDS; i++)
        if (int'(wrAddr) == ADDR_FIELD0 + i) shadowT[i] <= wrData;
      if (ctrlWr) begin
        shadowEn <= wrData[CB_EN];
        protect  <= wrData[CB_PROT];
      end
      if (int'(wrAddr) == ADDR_LTHR) lineThr <= wrData;
      if (int'(wrAddr) == ADDR_IRQEN) begin
        gIrqEn <= wrData[0];
        fIrqEn <= wrData[1];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      actT    <= '0;
      actEn   <= 1'b0;
      updPend <= 1'b0;
      irqPend <= 1'b0;
    end else if (softRst) begin
      actT    <= '0;
      actEn   <= 1'b0;
      updPend <= 1'b0;
      irqPend <= 1'b0;
    end else begin
      if (doCopy) begin
        actT  <= shadowT;
        actEn <= shadowEn;
      end
      if (ctrlWr && wrData[CB_UPD]) updPend <= 1'b1;
      else if (doCopy)              updPend <= 1'b0;
      if (irqSet)      irqPend <= 1'b1;
      else if (irqClr) irqPend <= 1'b0;
    end
  end

  always_comb begin
    cmd.run   = actEn;
    cmd.clear = softRst;
    irq       = irqPend;
  end

  // R6: a consumed request does not linger
  assert_upd_selfclr_R6: assert property (@(posedge clk) disable iff (!rstN)
    (doCopy && !ctrlWr) |=> !updPend);
  // R7: protected boundary leaves the active set untouched
  assert_protect_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    (evt.frameEdge && protect && !softRst) |=> ($stable(actT) && $stable(actEn)));
  // R8: pending only rises at a running vsync with both enables
  assert_irq_gate_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqPend) |-> $past(evt.vsyncPoint && gIrqEn && fIrqEn));
  // R9: write-one-to-clear
  assert_irq_clear_R9: assert property (@(posedge clk) disable iff (!rstN)
    (irqClr && !evt.vsyncPoint) |=> !irq);
endmodule

// File: rtl/shadow_vtg_dp.sv
module shadow_vtg_dp
  import shadow_vtg_pkg::*;
#(
  parameter int FW = 12,
  localparam int CW = FW + 2
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          pixTick,
  input  vtgCmd_t                       cmd,
  input  logic [NUM_FIELDS-1:0][FW-1:0] actT,
  input  logic [FW-1:0]                 lineThr,
  output vtgEvt_t                       evt,
  output logic                          hsync,
  output logic                          vsync,
  output logic                          de,
  output logic                          lineMatch,
  output logic [FW-1:0]                 pixX,
  output logic [FW-1:0]                 pixY
);
  logic [CW-1:0] hCnt, vCnt;
  logic [1:0][CW-1:0] axCnt, axLast;
  logic [1:0][FW-1:0] axOffs;
  logic [1:0] axSync, axAct;
  logic lastH, lastV;

  assign axCnt = {vCnt, hCnt};

  // index 0 is the horizontal axis, index 1 the vertical axis
  for (genvar g = 0; g < 2; g++) begin : gAxis
    shadow_vtg_axis #(.FW(FW)) axis_i (
      .cnt     (axCnt[g]),
      .syncM1  (actT[g*FIELDS_PER_AXIS + F_SYNC]),
      .backM1  (actT[g*FIELDS_PER_AXIS + F_BACK]),
      .actM1   (actT[g*FIELDS_PER_AXIS + F_ACT]),
      .frontM1 (actT[g*FIELDS_PER_AXIS + F_FRONT]),
      .lastPos (axLast[g]),
      .inSync  (axSync[g]),
      .inAct   (axAct[g]),
      .offs    (axOffs[g])
    );
  end

  always_comb begin
    lastH          = hCnt == axLast[0];
    lastV          = vCnt == axLast[1];
    evt.frameEdge  = pixTick && (!cmd.run || (lastH && lastV));
    evt.vsyncPoint = pixTick && cmd.run && lastH && lastV;
    hsync          = cmd.run && axSync[0];
    vsync          = cmd.run && axSync[1];
    de             = cmd.run && axAct[0] && axAct[1];
    pixX           = de ? axOffs[0] : '0;
    pixY           = de ? axOffs[1] : '0;
    lineMatch      = cmd.run && (vCnt == CW'(lineThr));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hCnt <= '0;
      vCnt <= '0;
    end else if (cmd.clear) begin
      hCnt <= '0;
      vCnt <= '0;
    end else if (pixTick) begin
      if (!cmd.run) begin
        hCnt <= '0;
        vCnt <= '0;
      end else if (lastH) begin
        hCnt <= '0;
        vCnt <= lastV ? '0 : vCnt + CW'(1);
      end else begin
        hCnt <= hCnt + CW'(1);
      end
    end
  end

  // R2: column never runs past the programmed line length
  assert_hpos_bound_R2: assert property (@(posedge clk) disable iff (!rstN)
    cmd.run |-> (hCnt <= axLast[0]));
  // R3: row never runs past the programmed frame height
  assert_vpos_bound_R3: assert property (@(posedge clk) disable iff (!rstN)
    cmd.run |-> (vCnt <= axLast[1]));
  // R3: vsync only starts right after a boundary
  assert_vsync_start_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(vsync) |-> $past(evt.frameEdge));
  // R4: active data never overlaps a sync pulse
  assert_de_excl_R4: assert property (@(posedge clk) disable iff (!rstN)
    de |-> (!hsync && !vsync));
  // R11: idle position stays at origin
  assert_idle_origin_R11: assert property (@(posedge clk) disable iff (!rstN)
    (!cmd.run && pixTick) |=> (hCnt == '0 && vCnt == '0));
endmodule

// File: rtl/shadow_vtg.sv
module shadow_vtg
  import shadow_vtg_pkg::*;
#(
  parameter int FW = 12,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          pixTick,
  input  logic          wrEn,
  input  logic [AW-1:0] wrAddr,
  input  logic [FW-1:0] wrData,
  output logic          hsync,
  output logic          vsync,
  output logic          de,
  output logic [FW-1:0] pixX,
  output logic [FW-1:0] pixY,
  output logic          lineMatch,
  output logic          irq
);
  vtgCmd_t cmd;
  vtgEvt_t evt;
  logic [NUM_FIELDS-1:0][FW-1:0] actT;
  logic [FW-1:0] lineThr;

  shadow_vtg_ctrl #(.FW(FW), .AW(AW)) ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .wrEn    (wrEn),
    .wrAddr  (wrAddr),
    .wrData  (wrData),
    .evt     (evt),
    .cmd     (cmd),
    .actT    (actT),
    .lineThr (lineThr),
    .irq     (irq)
  );

  shadow_vtg_dp #(.FW(FW)) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .pixTick   (pixTick),
    .cmd       (cmd),
    .actT      (actT),
    .lineThr   (lineThr),
    .evt       (evt),
    .hsync     (hsync),
    .vsync     (vsync),
    .de        (de),
    .lineMatch (lineMatch),
    .pixX      (pixX),
    .pixY      (pixY)
  );
endmodule

// File: tb/shadow_vtg_tb_top.sv
`timescale 1ns/1ps
module shadow_vtg_tb_top;
  localparam int FW = 12;
  localparam int AW = 4;
  localparam int THR = 3;
  localparam int LIMIT = 200000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic pixTick = 1'b0;
  logic wrEn = 1'b0;
  logic [AW-1:0] wrAddr = '0;
  logic [FW-1:0] wrData = '0;
  logic hsync, vsync, de, lineMatch, irq;
  logic [FW-1:0] pixX, pixY;

  logic tickRun = 1'b0;
  int testCnt = 0;
  int failCnt = 0;
  int popCount = 0;
  bit done = 1'b0;

  // expected item: {hsync, vsync, de, lineMatch, pixX, pixY}
  logic [4+2*FW-1:0] expQ[$];
  string tagQ[$];

  always #10 clk = ~clk;

  shadow_vtg #(.FW(FW), .AW(AW)) dut_i (
    .clk(clk), .rstN(rstN), .pixTick(pixTick), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .hsync(hsync), .vsync(vsync), .de(de), .pixX(pixX),
    .pixY(pixY), .lineMatch(lineMatch), .irq(irq)
  );

  initial forever begin
    @(posedge clk);
    #2 pixTick = tickRun ? ~pixTick : 1'b0;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    testCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input int addr, input int data);
    @(posedge clk);
    #2 wrEn = 1'b1; wrAddr = AW'(addr); wrData = FW'(data);
    @(posedge clk);
    #2 wrEn = 1'b0;
  endtask

  task automatic pushIdle(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      expQ.push_back('0);
      tagQ.push_back(tag);
    end
  endtask

  // expected raster from R2/R3/R4/R10, counts given directly (not minus one)
  task automatic pushFrame(input int hs, input int hb, input int ha, input int hf,
                           input int vs, input int vb, input int va, input int vf,
                           input string tag);
    for (int v = 0; v < vs + vb + va + vf; v++) begin
      for (int h = 0; h < hs + hb + ha + hf; h++) begin
        logic hin, vin, d;
        logic [FW-1:0] ex, ey;
        hin = (h >= hs + hb) && (h < hs + hb + ha);
        vin = (v >= vs + vb) && (v < vs + vb + va);
        d = hin && vin;
        ex = d ? FW'(h - hs - hb) : '0;
        ey = d ? FW'(v - vs - vb) : '0;
        expQ.push_back({h < hs, v < vs, d, v == THR, ex, ey});
        tagQ.push_back(tag);
      end
    end
  endtask

  task automatic progTiming(input int hs, input int hb, input int ha, input int hf,
                            input int vs, input int vb, input int va, input int vf);
    wr(1, hs - 1); wr(2, hb - 1); wr(3, ha - 1); wr(4, hf - 1);
    wr(5, vs - 1); wr(6, vb - 1); wr(7, va - 1); wr(8, vf - 1);
  endtask

  // monitor: pops one expected item per tick; lineMatch field covers R10
  always @(negedge clk) begin
    if (pixTick && expQ.size() > 0) begin
      logic [4+2*FW-1:0] expv, actv;
      string tag;
      expv = expQ.pop_front();
      tag = tagQ.pop_front();
      actv = {hsync, vsync, de, lineMatch, pixX, pixY};
      testCnt++;
      if (actv !== expv) begin
        failCnt++;
        $display("FAIL %s tick %0d actual=%h expected=%h", tag, popCount, actv, expv);
      end
      popCount++;
    end
  end

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
      $finish;
    end
  endtask

  initial begin
    #(20.0 * LIMIT);
    testCnt++;
    failCnt++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", popCount, 318);
    finishRun();
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk({hsync, vsync, de, lineMatch, irq} == 5'b0, "R1 flags", {hsync, vsync, de, lineMatch, irq}, 0);
    chk(pixX == 0 && pixY == 0, "R1 coords", int'(pixX) + int'(pixY), 0);

    // config A: line 2+1+4+2=9 ticks, frame 1+1+3+1=6 lines
    progTiming(2, 1, 4, 2, 1, 1, 3, 1);
    wr(9, THR);
    wr(10, 3);
    wr(0, 3);   // enable + update
    pushIdle(1, "R11");
    pushFrame(2, 1, 4, 2, 1, 1, 3, 1, "R2/R3/R10");
    pushFrame(2, 1, 4, 2, 1, 1, 3, 1, "R5");
    pushFrame(2, 1, 4, 2, 1, 1, 3, 1, "R7");
    pushFrame(1, 2, 3, 1, 2, 1, 2, 2, "R7");
    pushFrame(1, 2, 3, 1, 2, 1, 2, 2, "R6");
    pushFrame(1, 2, 3, 1, 2, 1, 2, 2, "R4");
    pushIdle(4, "R11");
    tickRun = 1'b1;

    wait (popCount >= 60);
    chk(irq == 1'b1, "R8 set at vsync", irq, 1);
    wr(11, 1);
    @(negedge clk);
    chk(irq == 1'b0, "R9 clear", irq, 0);
    progTiming(1, 2, 3, 1, 2, 1, 2, 2);   // config B into shadow only (R5)
    wr(0, 7);                               // enable + update + protect

    wait (popCount >= 114);
    wr(0, 1);                               // drop protect, request still pending

    wait (popCount >= 168);
    wr(3, 4);                               // shadow change without update (R6)

    wait (popCount >= 217);
    wr(10, 1);                              // global only
    wr(11, 1);

    wait (popCount >= 266);
    chk(irq == 1'b0, "R8 needs both enables", irq, 0);
    wr(10, 3);
    wr(0, 2);                               // update with enable off

    wait (popCount >= 314);
    tickRun = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(irq == 1'b1, "R8 set at last running vsync", irq, 1);
    wr(0, 3);                               // pending request
    wr(0, 8);                               // soft reset
    @(negedge clk);
    chk({hsync, vsync, de, lineMatch} == 4'b0, "R12 outputs", {hsync, vsync, de, lineMatch}, 0);
    chk(irq == 1'b0, "R12 irq cleared", irq, 1'b0);
    pushIdle(4, "R12");
    tickRun = 1'b1;
    wait (popCount >= 318);
    tickRun = 1'b0;
    repeat (2) @(posedge clk);
    finishRun();
  end
endmodule